// File: doc/BRIEF.md
# Break-aware resynchronizing serial receiver

This block receives an asynchronous serial line and turns it into bytes. The character format is fixed at one start bit, eight data bits sent least significant bit first, and two stop bits, with no parity. The bit rate is set at compile time by a clock divider that produces a 16x oversampling tick. The line idles high.

Besides a byte strobe, the receiver reports two kinds of faults on separate pulses. A framing error is a low stop bit in an otherwise ordinary character. A break is a low level that runs on from a start edge for longer than a whole character. Break lengths that are not a whole number of characters are handled. After either fault, the receiver waits for the line to go high and then for a fresh falling edge. A line that stays low never starts a character. When a break ends, the rising edge gives one break-end pulse and no byte. The edge hunt is re-armed on that same clock, so a mark of only a few bit times before the next start bit is enough. This suits framed lighting-control streams, where each frame opens with a break.

Top module: `serial_brk_rx`

## Requirements
- R1: A start bit is accepted only on a high-to-low transition of the synchronized line. After a framing error, a line held low produces no further event until it has gone high and then falls again.
- R2: After a start edge, each bit is sampled at its middle, and data is taken least significant bit first. `valid_o` pulses for one clock at the middle of the second stop bit, with the byte on `data_o`. Characters sent back to back with no idle gap are all received.
- R3: If either stop-bit sample is low, and the line was not low without a break since the start edge, `frame_err_o` pulses for exactly one clock and no byte is emitted. The receiver then waits for the line to be high.
- R4: If the line stays low without a break from the start edge for BRK_BITS bit times (default 12, longer than the 11-bit character), `brk_start_o` pulses exactly once. No framing error and no byte are reported for that low period.
- R5: `brk_end_o` pulses once, on the first clock where the synchronized line is high after a break. No byte is produced by that rising edge. A mark of 3 bit times after the break is enough for the next character to be received correctly.
- R6: A start bit that reads high at its midpoint is dropped without any event, and edge hunting resumes.
- R7: If the line was low without a break through the stop-bit sample but rises before the break threshold, a single `frame_err_o` pulse is given when the line rises, and not earlier.
- R8: While and after reset all strobes are low, and an idle high line produces no events.
- R9: At most one of `valid_o`, `frame_err_o`, `brk_start_o` and `brk_end_o` is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idles high |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-clock pulse: `data_o` holds a new byte |
| frame_err_o | output | 1 | One-clock pulse: low stop bit seen |
| brk_start_o | output | 1 | One-clock pulse: break detected |
| brk_end_o | output | 1 | One-clock pulse: line high after break |

## Verification
A receiver that goes wrong inside, such as a bit counter that has slipped, a stale continuous-low flag, or a state that re-arms on a level, shows at the ports within one character time. The symptom is a wrong byte value, a byte where a fault pulse was due, a run of framing errors during a long break, or an extra byte when a break ends. The scoreboard matches every strobe against an ordered list of expected events. Any event that is missing, moved or unexpected is therefore caught at the clock where it happens. Breaks of fractional length and minimum marks are driven so that phase slips after resynchronization show up in the next byte.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int BRX_DATA_W = 8;
  localparam int BRX_STOP_N = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD,
    ST_BREAK,
    ST_WAIT
  } brx_state_e;
endpackage

// File: rtl/brx_sync.sv
module brx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic rx_o,
  output logic rx_prev_o
);
  // [STAGES-1] is the synchronized bit, [STAGES] its one-clock-old copy.
  // Reset low so a line that is already high gives no falling edge.
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], rxd_i};
  end

  assign rx_o      = pipe_q[STAGES-1];
  assign rx_prev_o = pipe_q[STAGES];
endmodule

// File: rtl/brx_tick.sv
module brx_tick #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/brx_fsm.sv
module brx_fsm
  import brx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int BRK_BITS = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rx_i,
  input  logic                  rx_prev_i,
  input  logic                  tick_i,
  output logic                  tick_clr_o,
  output logic [BRX_DATA_W-1:0] data_o,
  output logic                  valid_o,
  output logic                  frame_err_o,
  output logic                  brk_start_o,
  output logic                  brk_end_o
);
  localparam int OS_W      = $clog2(OVS);
  localparam int HALF      = OVS / 2;
  localparam int BRK_TICKS = BRK_BITS * OVS;
  localparam int BC_W      = $clog2(BRK_TICKS + 1);
  localparam int BIT_W     = $clog2(BRX_DATA_W);

  brx_state_e            state_q;
  logic [OS_W-1:0]       os_q;
  logic [BIT_W-1:0]      bit_q;
  logic [BC_W-1:0]       brk_q;
  logic                  all_low_q;
  logic [BRX_DATA_W-1:0] sh_q;
  logic                  fall;

  assign fall       = rx_prev_i && !rx_i;
  assign tick_clr_o = (state_q == ST_IDLE) && fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      os_q        <= '0;
      bit_q       <= '0;
      brk_q       <= '0;
      all_low_q   <= 1'b0;
      sh_q        <= '0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      brk_start_o <= 1'b0;
      brk_end_o   <= 1'b0;
    end else begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      brk_start_o <= 1'b0;
      brk_end_o   <= 1'b0;
      // ticks since start edge, saturating
      if (tick_i && brk_q != BC_W'(BRK_TICKS)) brk_q <= brk_q + 1'b1;
      if (rx_i) all_low_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (fall) begin
          state_q   <= ST_START;
          os_q      <= '0;
          brk_q     <= '0;
          all_low_q <= 1'b1;
        end
        ST_START: if (tick_i) begin
          if (os_q == OS_W'(HALF - 1)) begin
            os_q  <= '0;
            bit_q <= '0;
            state_q <= rx_i ? ST_IDLE : ST_DATA;
          end else os_q <= os_q + 1'b1;
        end
        ST_DATA: if (tick_i) begin
          if (os_q == OS_W'(OVS - 1)) begin
            os_q <= '0;
            sh_q <= {rx_i, sh_q[BRX_DATA_W-1:1]};
            if (bit_q == BIT_W'(BRX_DATA_W - 1)) begin
              bit_q   <= '0;
              state_q <= ST_STOP;
            end else bit_q <= bit_q + 1'b1;
          end else os_q <= os_q + 1'b1;
        end
        ST_STOP: if (tick_i) begin
          if (os_q == OS_W'(OVS - 1)) begin
            os_q <= '0;
            if (!rx_i) begin
              if (all_low_q) state_q <= ST_HOLD;
              else begin
                frame_err_o <= 1'b1;
                state_q     <= ST_WAIT;
              end
            end else if (bit_q == BIT_W'(BRX_STOP_N - 1)) begin
              data_o  <= sh_q;
              valid_o <= 1'b1;
              state_q <= ST_IDLE;
            end else bit_q <= bit_q + 1'b1;
          end else os_q <= os_q + 1'b1;
        end
        // zero char with low stop: break or plain framing error, decided here
        ST_HOLD: begin
          if (rx_i) begin
            frame_err_o <= 1'b1;
            state_q     <= ST_IDLE;
          end else if (brk_q == BC_W'(BRK_TICKS)) begin
            brk_start_o <= 1'b1;
            state_q     <= ST_BREAK;
          end
        end
        ST_BREAK: if (rx_i) begin
          brk_end_o <= 1'b1;
          state_q   <= ST_IDLE;
        end
        ST_WAIT: if (rx_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_brk_rx.sv
module serial_brk_rx
  import brx_pkg::*;
#(
  parameter int DIV         = 12,
  parameter int OVS         = 16,
  parameter int BRK_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rxd_i,
  output logic [BRX_DATA_W-1:0] data_o,
  output logic                  valid_o,
  output logic                  frame_err_o,
  output logic                  brk_start_o,
  output logic                  brk_end_o
);
  logic rx, rx_prev, tick, tick_clr;

  brx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rxd_i    (rxd_i),
    .rx_o     (rx),
    .rx_prev_o(rx_prev)
  );

  brx_tick #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tick_clr),
    .tick_o(tick)
  );

  brx_fsm #(.OVS(OVS), .BRK_BITS(BRK_BITS)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx),
    .rx_prev_i  (rx_prev),
    .tick_i     (tick),
    .tick_clr_o (tick_clr),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .frame_err_o(frame_err_o),
    .brk_start_o(brk_start_o),
    .brk_end_o  (brk_end_o)
  );
endmodule

// File: rtl/brx_chk.sv
module brx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic fe_i,
  input logic bs_i,
  input logic be_i
);
  logic in_brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   in_brk_q <= 1'b0;
    else if (bs_i) in_brk_q <= 1'b1;
    else if (be_i) in_brk_q <= 1'b0;
  end

  // R9
  one_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_i, fe_i, bs_i, be_i}));
  // R4
  brk_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_i |-> !in_brk_q);
  // R5
  brk_end_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_i |-> in_brk_q);
  // R4
  no_byte_in_brk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i || fe_i) |-> !in_brk_q);
  // R3
  fe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_i |=> !fe_i);
  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);
endmodule

bind serial_brk_rx brx_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_o),
  .fe_i   (frame_err_o),
  .bs_i   (brk_start_o),
  .be_i   (brk_end_o)
);

// File: tb/sim_serial_brk_rx.sv
module sim_serial_brk_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 12;
  localparam int OVS = 16;
  localparam int BIT = DIV * OVS;
  localparam int K_BYTE = 0, K_FE = 1, K_BS = 2, K_BE = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] data;
  logic       valid, fe, bs, be;

  serial_brk_rx #(.DIV(DIV), .OVS(OVS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rxd_i(rxd), .data_o(data),
    .valid_o(valid), .frame_err_o(fe), .brk_start_o(bs), .brk_end_o(be)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int    kind;
    int    data;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0, n_bad = 0, n_evt = 0;
  bit   done = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(int k, int d, string t);
    exp_t e;
    e.kind = k; e.data = d; e.tag = t;
    q.push_back(e);
  endtask

  task automatic line(bit v, int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(logic [7:0] b, bit s1 = 1'b1, bit s2 = 1'b1);
    line(1'b0, BIT);
    for (int i = 0; i < 8; i++) line(b[i], BIT);
    line(s1, BIT);
    line(s2, BIT);
  endtask

  // monitor: codes are kind*256+data
  always @(negedge clk) begin
    if (rst_ni && (valid || fe || bs || be)) begin
      int k;
      int d;
      k = valid ? K_BYTE : fe ? K_FE : bs ? K_BS : K_BE;
      d = valid ? int'(data) : 0;
      n_evt++;
      if (q.size() == 0) chk(1'b0, "R1 unexpected event", k * 256 + d, -1);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(k == e.kind && d == e.data, e.tag, k * 256 + d, e.kind * 256 + e.data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=0", q.size());
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int e0;
    repeat (5) @(negedge clk);
    chk({data, valid, fe, bs, be} == '0, "R8 reset outputs", {data, valid, fe, bs, be}, 0);
    rst_ni = 1'b1;
    line(1'b1, 2 * BIT);
    chk(n_evt == 0, "R8 idle line silent", n_evt, 0);

    // R2 plain bytes
    expect_ev(K_BYTE, 8'h55, "R2 byte 55"); frame(8'h55); line(1'b1, BIT);
    expect_ev(K_BYTE, 8'hA3, "R2 byte A3"); frame(8'hA3); line(1'b1, BIT);
    expect_ev(K_BYTE, 8'h00, "R2 byte 00"); frame(8'h00); line(1'b1, BIT);
    expect_ev(K_BYTE, 8'hFF, "R2 byte FF"); frame(8'hFF); line(1'b1, BIT);
    expect_ev(K_BYTE, 8'h3C, "R2 back-to-back 3C");
    expect_ev(K_BYTE, 8'hC3, "R2 back-to-back C3");
    frame(8'h3C); frame(8'hC3); line(1'b1, 2 * BIT);

    // R3 low first stop, then low second stop
    expect_ev(K_FE, 0, "R3 stop1 low");
    frame(8'h5A, 1'b0, 1'b1); line(1'b1, BIT);
    expect_ev(K_BYTE, 8'h96, "R3 recovery byte 96");
    frame(8'h96); line(1'b1, BIT);
    expect_ev(K_FE, 0, "R3 stop2 low");
    frame(8'h11, 1'b1, 1'b0); line(1'b1, 2 * BIT);

    // R1 framing error then line held low: no restart on level
    expect_ev(K_FE, 0, "R1 fe before held low");
    frame(8'h0F, 1'b0, 1'b0);
    e0 = n_evt;
    line(1'b0, 5 * BIT);
    chk(n_evt == e0, "R1 held low no restart", n_evt - e0, 0);
    line(1'b1, BIT);
    expect_ev(K_BYTE, 8'h24, "R1 byte after release 24");
    frame(8'h24); line(1'b1, BIT);

    // R7 continuous low under break threshold
    expect_ev(K_FE, 0, "R7 short low fe");
    e0 = n_evt;
    line(1'b0, 11 * BIT);
    chk(n_evt == e0, "R7 no event before rise", n_evt - e0, 0);
    line(1'b1, 2 * BIT);
    chk(n_evt == e0 + 1, "R7 single fe on rise", n_evt - e0, 1);

    // R4/R5 break, 3-bit mark, start code and data
    expect_ev(K_BS, 0, "R4 break start");
    expect_ev(K_BE, 0, "R5 break end");
    expect_ev(K_BYTE, 8'h00, "R5 start code 00 after mark");
    expect_ev(K_BYTE, 8'h42, "R2 slot byte 42");
    e0 = n_evt;
    line(1'b0, 23 * BIT);
    chk(n_evt == e0 + 1, "R4 one event during break", n_evt - e0, 1);
    line(1'b1, 3 * BIT);
    frame(8'h00); frame(8'h42); line(1'b1, 2 * BIT);

    // R4/R5 fractional long break, minimum mark
    expect_ev(K_BS, 0, "R4 long fractional break");
    expect_ev(K_BE, 0, "R5 long break end");
    expect_ev(K_BYTE, 8'h7E, "R5 byte 7E after short mark");
    e0 = n_evt;
    line(1'b0, 40 * BIT + 61);
    chk(n_evt == e0 + 1, "R4 no fe run in long break", n_evt - e0, 1);
    line(1'b1, 3 * BIT);
    chk(n_evt == e0 + 2, "R5 no spurious byte at break end", n_evt - e0, 2);
    frame(8'h7E); line(1'b1, 2 * BIT);

    // R6 glitch start
    e0 = n_evt;
    line(1'b0, 36);
    line(1'b1, 2 * BIT);
    chk(n_evt == e0, "R6 glitch dropped", n_evt - e0, 0);
    expect_ev(K_BYTE, 8'h81, "R6 byte after glitch 81");
    frame(8'h81); line(1'b1, 2 * BIT);

    chk(q.size() == 0, "R2 all expected events seen", q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule